// File: doc/BRIEF.md
# Interrupt Controller Cascade Logic

This block joins one master interrupt controller and up to eight slave controllers into a single system of 64 levels, with eight levels on each slave. A configuration bit picks the role. As master, the block watches for the start of an interrupt acknowledge on the active-low acknowledge input. If the winning request level is marked as having a slave attached, the block places that level number on the shared 3-bit cascade lines. Otherwise it supplies its own vector on the data output and leaves the cascade lines at zero.

As slave, the block reads the cascade lines one cycle into the acknowledge. It compares them with its programmed identification number. It enables its vector output only when the two match, and it holds that decision until the acknowledge ends. In buffered mode, an active-low enable for the external bus transceivers follows the data enable of this device. Priority resolution is not part of this block: the winning level and the vector arrive as plain inputs.

All inputs are sampled on the rising clock edge. The acknowledge input is assumed to be synchronous to the clock.

Top module: `cascade_ctl`

## Requirements
- R1: After reset, `data_oe` and `cas_oe` are 0, `cas_out` and `data_out` are 0, and `buf_en_n` is 1.
- R2: In master mode (`cfg_master`=1), if bit L of `cfg_slave_map` is 1, then in the cycle after the first clock edge that samples `inta_n` low, `cas_out` equals the binary level number L (taken from `win_level`) and `cas_oe` is 1. In that same case `data_oe` stays 0.
- R3: In master mode, if the winning level's bit in `cfg_slave_map` is 0, then one cycle after the acknowledge starts, `data_oe` is 1 and `data_out` equals `own_vector`. In that case `cas_out` is 0 and `cas_oe` is 0.
- R4: While `inta_n` stays low, the master's cascade value is held, even if `win_level` changes.
- R5: In slave mode (`cfg_master`=0), `data_oe` is still 0 one cycle after the acknowledge starts. If `cas_in` equals `cfg_own_id` at the second edge that samples `inta_n` low, `data_oe` becomes 1 in the following cycle and `data_out` equals `own_vector`.
- R6: A slave whose `cas_in` did not match at that second edge keeps `data_oe` at 0 until `inta_n` rises, even if `cas_in` matches later.
- R7: When `cfg_buffered`=1, `buf_en_n` is 0 exactly while `data_oe` is 1. When `cfg_buffered`=0, `buf_en_n` stays 1.
- R8: In slave mode, `cas_oe` is 0 and `cas_out` is 0 at all times.
- R9: One cycle after an edge that samples `inta_n` high, `data_oe`, `cas_oe`, `cas_out` and `data_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_buffered | input | 1 | Enables the transceiver enable output |
| cfg_slave_map | input | 8 | Master: bit L set means level L has a slave attached |
| cfg_own_id | input | 3 | Slave: identification number |
| win_level | input | 3 | Winning request level from the priority resolver |
| own_vector | input | 8 | Vector this device supplies |
| inta_n | input | 1 | Active-low interrupt acknowledge |
| cas_in | input | 3 | Cascade lines as seen by a slave |
| cas_out | output | 3 | Cascade lines driven by a master |
| cas_oe | output | 1 | Drive enable for the cascade lines |
| data_out | output | 8 | Vector data |
| data_oe | output | 1 | Vector data output enable |
| buf_en_n | output | 1 | Active-low external transceiver enable |

## Verification
The bench builds the block with its default parameters: 8 levels, a 3-bit identification and an 8-bit vector. With these values it can reach the top level 7 and the full range of cascade codes. A single instance plays both roles, because the bench switches `cfg_master` between tests. In slave tests the bench drives `cas_in` directly, standing in for a master, so it can reach both matching and late-matching identification values.

// File: rtl/cascade_pkg.sv
// Package: shared parameters and the role encoding for the cascade logic.
// Assumes: nothing beyond IEEE 1800-2017.
package cascade_pkg;
    localparam int unsigned DEF_LEVELS = 8;
    localparam int unsigned DEF_VEC_W  = 8;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;
endpackage

// File: rtl/cascade_ack_track.sv
// Acknowledge tracker: derives the acknowledge phases from the active-low
// acknowledge input. 'start' marks the first edge that samples it low, and
// 'second' marks each later edge with it still low.
// Assumes: inta_n is synchronous to clk.
module cascade_ack_track (
    input  logic clk,
    input  logic rst_n,
    input  logic inta_n,
    output logic ack_live,
    output logic ack_start,
    output logic ack_later
);
    logic inta_q;

    // Remember the previous sample of the acknowledge input.
    always_ff @(posedge clk) begin
        if (!rst_n) inta_q <= 1'b1;
        else        inta_q <= inta_n;
    end

    // Phase decode from the current and previous samples.
    always_comb begin
        ack_live  = ~inta_n;
        ack_start = inta_q & ~inta_n;
        ack_later = ~inta_q & ~inta_n;
    end
endmodule

// File: rtl/cascade_master_drv.sv
// Master driver: at the start of an acknowledge, either drives the slave
// number onto the cascade lines or presents its own vector. It holds that
// choice until the acknowledge ends.
// Assumes: win_level is valid when the acknowledge starts.
module cascade_master_drv #(
    parameter int unsigned LEVELS = 8,
    parameter int unsigned VEC_W  = 8,
    localparam int unsigned ID_W  = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_live,
    input  logic              ack_start,
    input  logic [LEVELS-1:0] slave_map,
    input  logic [ID_W-1:0]   win_level,
    input  logic [VEC_W-1:0]  own_vector,
    output logic [ID_W-1:0]   cas_q,
    output logic              cas_oe_q,
    output logic              vec_oe_q,
    output logic [VEC_W-1:0]  vec_q
);
    logic [LEVELS-1:0] level_hot;
    logic              has_slave;

    // One-hot decode of the winning level, one bit per level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_dec
        assign level_hot[g] = (win_level == ID_W'(g));
    end

    // A slave is attached when the decoded level is marked in the map.
    always_comb has_slave = |(level_hot & slave_map);

    // Capture the acknowledge decision, then clear it once the acknowledge ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !ack_live) begin
            cas_q    <= '0;
            cas_oe_q <= 1'b0;
            vec_oe_q <= 1'b0;
            vec_q    <= '0;
        end else if (ack_start) begin
            cas_q    <= has_slave ? win_level : '0;
            cas_oe_q <= has_slave;
            vec_oe_q <= ~has_slave;
            vec_q    <= has_slave ? '0 : own_vector;
        end
    end
endmodule

// File: rtl/cascade_slave_cmp.sv
// Slave comparator: on the second acknowledge edge, compares the cascade lines
// with its own number and enables its vector only on a match. It makes the
// decision once per acknowledge.
// Assumes: the master settles the cascade lines within one cycle.
module cascade_slave_cmp #(
    parameter int unsigned ID_W  = 3,
    parameter int unsigned VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_live,
    input  logic             ack_later,
    input  logic [ID_W-1:0]  cas_in,
    input  logic [ID_W-1:0]  own_id,
    input  logic [VEC_W-1:0] own_vector,
    output logic             vec_oe_q,
    output logic [VEC_W-1:0] vec_q
);
    logic decided_q;
    logic id_match;

    // Identification compare.
    always_comb id_match = (cas_in == own_id);

    // Make one decision per acknowledge and hold it until release.
    always_ff @(posedge clk) begin
        if (!rst_n || !ack_live) begin
            decided_q <= 1'b0;
            vec_oe_q  <= 1'b0;
            vec_q     <= '0;
        end else if (ack_later && !decided_q) begin
            decided_q <= 1'b1;
            vec_oe_q  <= id_match;
            vec_q     <= id_match ? own_vector : '0;
        end
    end
endmodule

// File: rtl/cascade_bus_ctl.sv
// Bus control: selects the active role's outputs and forms the active-low
// transceiver enable in buffered mode.
// Assumes: role changes only between acknowledges.
module cascade_bus_ctl
    import cascade_pkg::*;
#(
    parameter int unsigned ID_W  = 3,
    parameter int unsigned VEC_W = 8
) (
    input  logic             is_master,
    input  logic             buffered,
    input  logic [ID_W-1:0]  m_cas,
    input  logic             m_cas_oe,
    input  logic             m_vec_oe,
    input  logic [VEC_W-1:0] m_vec,
    input  logic             s_vec_oe,
    input  logic [VEC_W-1:0] s_vec,
    output logic [ID_W-1:0]  cas_out,
    output logic             cas_oe,
    output logic [VEC_W-1:0] data_out,
    output logic             data_oe,
    output logic             buf_en_n
);
    role_e role;

    // Role multiplexing of the cascade and data outputs.
    always_comb begin
        role = role_e'(is_master);
        if (role == ROLE_MASTER) begin
            cas_out  = m_cas;
            cas_oe   = m_cas_oe;
            data_oe  = m_vec_oe;
            data_out = m_vec;
        end else begin
            cas_out  = '0;
            cas_oe   = 1'b0;
            data_oe  = s_vec_oe;
            data_out = s_vec;
        end
        buf_en_n = ~(buffered & data_oe);
    end
endmodule

// File: rtl/cascade_ctl.sv
// Top: master/slave cascade logic for an 8-level interrupt controller.
// Assumes: inta_n is synchronous to clk; configuration is static during an
// acknowledge.
module cascade_ctl #(
    parameter int unsigned LEVELS = cascade_pkg::DEF_LEVELS,
    parameter int unsigned VEC_W  = cascade_pkg::DEF_VEC_W,
    localparam int unsigned ID_W  = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_buffered,
    input  logic [LEVELS-1:0] cfg_slave_map,
    input  logic [ID_W-1:0]   cfg_own_id,
    input  logic [ID_W-1:0]   win_level,
    input  logic [VEC_W-1:0]  own_vector,
    input  logic              inta_n,
    input  logic [ID_W-1:0]   cas_in,
    output logic [ID_W-1:0]   cas_out,
    output logic              cas_oe,
    output logic [VEC_W-1:0]  data_out,
    output logic              data_oe,
    output logic              buf_en_n
);
    logic             ack_live, ack_start, ack_later;
    logic [ID_W-1:0]  m_cas;
    logic             m_cas_oe, m_vec_oe, s_vec_oe;
    logic [VEC_W-1:0] m_vec, s_vec;

    cascade_ack_track i_ack (
        .clk(clk), .rst_n(rst_n), .inta_n(inta_n),
        .ack_live(ack_live), .ack_start(ack_start), .ack_later(ack_later)
    );

    cascade_master_drv #(.LEVELS(LEVELS), .VEC_W(VEC_W)) i_mst (
        .clk(clk), .rst_n(rst_n), .ack_live(ack_live), .ack_start(ack_start),
        .slave_map(cfg_slave_map), .win_level(win_level), .own_vector(own_vector),
        .cas_q(m_cas), .cas_oe_q(m_cas_oe), .vec_oe_q(m_vec_oe), .vec_q(m_vec)
    );

    cascade_slave_cmp #(.ID_W(ID_W), .VEC_W(VEC_W)) i_slv (
        .clk(clk), .rst_n(rst_n), .ack_live(ack_live), .ack_later(ack_later),
        .cas_in(cas_in), .own_id(cfg_own_id), .own_vector(own_vector),
        .vec_oe_q(s_vec_oe), .vec_q(s_vec)
    );

    cascade_bus_ctl #(.ID_W(ID_W), .VEC_W(VEC_W)) i_bus (
        .is_master(cfg_master), .buffered(cfg_buffered),
        .m_cas(m_cas), .m_cas_oe(m_cas_oe), .m_vec_oe(m_vec_oe), .m_vec(m_vec),
        .s_vec_oe(s_vec_oe), .s_vec(s_vec),
        .cas_out(cas_out), .cas_oe(cas_oe), .data_out(data_out),
        .data_oe(data_oe), .buf_en_n(buf_en_n)
    );
endmodule

// File: rtl/cascade_ctl_chk.sv
// Checker: port-level temporal properties of the cascade logic, bound to the top.
module cascade_ctl_chk #(
    parameter int unsigned ID_W  = 3,
    parameter int unsigned VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_master,
    input logic             cfg_buffered,
    input logic [ID_W-1:0]  cfg_own_id,
    input logic             inta_n,
    input logic [ID_W-1:0]  cas_in,
    input logic [ID_W-1:0]  cas_out,
    input logic             cas_oe,
    input logic [VEC_W-1:0] data_out,
    input logic             data_oe,
    input logic             buf_en_n
);
    // R2/R3: a master never drives the cascade lines and the data bus together.
    p_exclusive_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> !data_oe);

    // R4: the master's cascade value holds while the acknowledge continues.
    p_hold_cas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !inta_n && !$past(inta_n)) |=> $stable(cas_out));

    // R6: a slave enables data only after a matching cascade sample.
    p_slave_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && $rose(data_oe)) |-> ($past(cas_in) == $past(cfg_own_id)));

    // R7: the buffered enable follows the data enable.
    p_buf_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_buffered && data_oe) |-> !buf_en_n);

    // R7: without buffered mode, the enable stays inactive.
    p_buf_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_buffered |-> buf_en_n);

    // R8: a slave leaves the cascade lines undriven.
    p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!cas_oe && cas_out == '0));

    // R9: everything is released after a high acknowledge sample.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inta_n) |-> (!data_oe && !cas_oe && data_out == '0));
endmodule

bind cascade_ctl cascade_ctl_chk #(.ID_W(ID_W), .VEC_W(VEC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_buffered(cfg_buffered),
    .cfg_own_id(cfg_own_id), .inta_n(inta_n), .cas_in(cas_in),
    .cas_out(cas_out), .cas_oe(cas_oe), .data_out(data_out),
    .data_oe(data_oe), .buf_en_n(buf_en_n)
);

// File: tb/test_cascade_ctl.sv
// Directed bench for cascade_ctl: one task per scenario, each checking itself.
module test_cascade_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1;
    logic       cfg_buffered = 1'b0;
    logic [7:0] cfg_slave_map = 8'h00;
    logic [2:0] cfg_own_id = 3'd0;
    logic [2:0] win_level = 3'd0;
    logic [7:0] own_vector = 8'h00;
    logic       inta_n = 1'b1;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;
    logic       cas_oe;
    logic [7:0] data_out;
    logic       data_oe;
    logic       buf_en_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cascade_ctl i_cascade_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_buffered(cfg_buffered),
        .cfg_slave_map(cfg_slave_map), .cfg_own_id(cfg_own_id), .win_level(win_level),
        .own_vector(own_vector), .inta_n(inta_n), .cas_in(cas_in),
        .cas_out(cas_out), .cas_oe(cas_oe), .data_out(data_out),
        .data_oe(data_oe), .buf_en_n(buf_en_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic release_ack();
        inta_n = 1'b1;
        step();
        chk("R9 data_oe", int'(data_oe), 0);
        chk("R9 cas_oe", int'(cas_oe), 0);
        chk("R9 cas_out", int'(cas_out), 0);
        chk("R9 data_out", int'(data_out), 0);
        step();
    endtask

    task automatic t_reset();
        chk("R1 data_oe", int'(data_oe), 0);
        chk("R1 cas_oe", int'(cas_oe), 0);
        chk("R1 cas_out", int'(cas_out), 0);
        chk("R1 data_out", int'(data_out), 0);
        chk("R1 buf_en_n", int'(buf_en_n), 1);
    endtask

    task automatic t_master_slave_level();
        cfg_master = 1'b1; cfg_buffered = 1'b1; cfg_slave_map = 8'b1010_0100;
        win_level = 3'd2; own_vector = 8'h42;
        step();
        inta_n = 1'b0;
        step();
        chk("R2 cas_out", int'(cas_out), 2);
        chk("R2 cas_oe", int'(cas_oe), 1);
        chk("R2 data_oe", int'(data_oe), 0);
        chk("R7 buf idle when not driving data", int'(buf_en_n), 1);
        win_level = 3'd5;
        step();
        chk("R4 cas_out held", int'(cas_out), 2);
        step();
        chk("R4 cas_out still held", int'(cas_out), 2);
        release_ack();
    endtask

    task automatic t_master_top_level();
        cfg_master = 1'b1; cfg_buffered = 1'b0; cfg_slave_map = 8'h80;
        win_level = 3'd7;
        inta_n = 1'b0;
        step();
        chk("R2 top level cas_out", int'(cas_out), 7);
        chk("R2 top level cas_oe", int'(cas_oe), 1);
        release_ack();
    endtask

    task automatic t_master_own_vector();
        cfg_master = 1'b1; cfg_buffered = 1'b1; cfg_slave_map = 8'b1010_0100;
        win_level = 3'd3; own_vector = 8'h5A;
        inta_n = 1'b0;
        step();
        chk("R3 data_oe", int'(data_oe), 1);
        chk("R3 data_out", int'(data_out), 'h5A);
        chk("R3 cas_out", int'(cas_out), 0);
        chk("R3 cas_oe", int'(cas_oe), 0);
        chk("R7 buf_en_n buffered", int'(buf_en_n), 0);
        release_ack();
        chk("R7 buf_en_n after release", int'(buf_en_n), 1);
    endtask

    task automatic t_slave_match(input bit buffered);
        cfg_master = 1'b0; cfg_buffered = buffered; cfg_own_id = 3'd5;
        cas_in = 3'd5; own_vector = 8'h77;
        inta_n = 1'b0;
        step();
        chk("R5 slave not yet enabled", int'(data_oe), 0);
        chk("R8 slave cas_oe", int'(cas_oe), 0);
        step();
        chk("R5 slave data_oe", int'(data_oe), 1);
        chk("R5 slave data_out", int'(data_out), 'h77);
        chk("R8 slave cas_out", int'(cas_out), 0);
        chk("R7 slave buf_en_n", int'(buf_en_n), buffered ? 0 : 1);
        release_ack();
    endtask

    task automatic t_slave_mismatch();
        cfg_master = 1'b0; cfg_buffered = 1'b1; cfg_own_id = 3'd5;
        cas_in = 3'd3; own_vector = 8'h33;
        inta_n = 1'b0;
        step();
        step();
        chk("R6 mismatch data_oe", int'(data_oe), 0);
        chk("R6 mismatch buf_en_n", int'(buf_en_n), 1);
        cas_in = 3'd5;
        step();
        step();
        chk("R6 late match ignored", int'(data_oe), 0);
        chk("R6 late match data_out", int'(data_out), 0);
        release_ack();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_master_slave_level();
        t_master_top_level();
        t_master_own_vector();
        t_slave_match(1'b0);
        t_slave_match(1'b1);
        t_slave_mismatch();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule